// File: doc/BRIEF.md
# Thermal-Aware Cache Bank Gating Controller

This controller manages the power state of a banked last-level cache. A free-running interval timer marks reconfiguration boundaries. At each boundary the controller captures per-bank access counts, per-bank temperatures and a performance-degradation figure, and restarts the access counters. One cycle later it makes a decision from the captured values only.

When degradation is over the configured budget, every gated bank is woken. When degradation is within budget and fewer than half the banks are off, the hottest eligible bank is drained into a target bank and then switched off. Eligible means powered and not serving as a target. The drain is a request/acknowledge exchange with an external migration engine. While the drain runs, the target bank is stalled. After the acknowledge, the drained bank is gated and a remap entry is written. From then on, a combinational lookup redirects the gated bank's index to its target.

The target can be chosen in two ways. In free mode the controller picks the least-used powered bank. In clustered mode the banks form groups of four, and the first bank of each group is the permanent target for the other three.

Top module: `llc_gate_ctrl`

## Requirements
- R1: The number of banks with `pg_en` low never exceeds NBANK/2. A decision taken at that limit starts no drain.
- R2: If the captured degradation is strictly greater than `deg_limit` and some bank is off, `pg_en` becomes all ones on the edge after the decision. Remap entries are cleared one edge later, so the lookup redirect remains for exactly one cycle after wake. A degradation equal to the limit counts as within budget.
- R3: Within budget, the victim is the powered, non-target bank with the highest captured temperature. Ties go to the lowest index.
- R4: A drain raises `flush_req` with `flush_src` and `flush_dst`. On the edge where `flush_done` is sampled high, `flush_req` falls, `pg_en[flush_src]` goes low and the remap entry is written. A bank is never gated any other way.
- R5: `stall` is zero except while `flush_req` is high. During a drain exactly bit `flush_dst` is set.
- R6: In free mode, the target is the powered bank other than the victim with the fewest captured accesses. Ties go to the lowest index.
- R7: Only one drain runs at a time. A boundary that passes during a drain is remembered. The deferred decision is taken on the second edge after the drain completes, so `flush_req` is low for exactly two samples when a further victim exists.
- R8: In clustered mode (`cluster_mode`=1), a bank whose index is a multiple of 4 is never gated. Its group's other banks drain into it.
- R9: `lookup_target` equals `lookup_bank` when that bank's remap entry is invalid, and equals the stored target otherwise.
- R10: Every INTERVAL cycles the counts, temperatures and degradation are captured and the counters restart. The decision follows on the next edge and uses only the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_hit | input | NBANK | One bit per bank, high for a cycle with an access |
| temp_flat | input | NBANK*TEMP_W | Per-bank temperature readings, bank i at bits i*TEMP_W |
| perf_deg | input | DEG_W | Current performance degradation figure |
| deg_limit | input | DEG_W | Degradation budget (typically 3) |
| cluster_mode | input | 1 | 1 selects fixed groups of four; change only while all banks are on |
| flush_done | input | 1 | One-cycle acknowledge of the current drain |
| lookup_bank | input | log2(NBANK) | Bank index to translate |
| pg_en | output | NBANK | Power enable per bank, 1 = powered |
| flush_req | output | 1 | Drain in progress |
| flush_src | output | log2(NBANK) | Bank being drained |
| flush_dst | output | log2(NBANK) | Bank receiving the contents |
| stall | output | NBANK | Per-bank request stall |
| lookup_target | output | log2(NBANK) | Translated bank index |

## Verification
The hardest state to reach is a drain that spans an interval boundary. The remembered boundary must then produce a fresh decision exactly two edges after the acknowledge. The stimulus reaches this state by making the migration responder wait longer than one interval before it acknowledges. The bench then times the gap in `flush_req`. The one-cycle window after wake is also narrow: banks are powered again, but the remap entries still redirect. The bench reaches it by raising degradation over the budget while the lookup input is held on a gated bank. Clustered mode is driven with the group-leader banks made the hottest, so the leader exclusion decides the outcome.

// File: rtl/llc_gate_pkg.sv
// Shared types for the cache bank gating controller.
// Assumes: nothing beyond the enum encoding below.
package llc_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_WAKE   = 2'd3
    } gate_state_e;

endpackage

// File: rtl/lgc_stats.sv
// Interval timer and per-bank statistics capture.
// At the last cycle of every interval the running access counts, the live
// temperatures and the degradation figure are copied into snapshot
// registers. The counters restart, counting the access of that same cycle.
// Assumes: INTERVAL >= 4.
module lgc_stats #(
    parameter int NBANK    = 16,
    parameter int CNT_W    = 16,
    parameter int TEMP_W   = 8,
    parameter int DEG_W    = 8,
    parameter int INTERVAL = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBANK-1:0]         acc_hit,
    input  logic [NBANK*TEMP_W-1:0]  temp_flat,
    input  logic [DEG_W-1:0]         perf_deg,
    output logic                     tick,
    output logic [NBANK*CNT_W-1:0]   snap_cnt_flat,
    output logic [NBANK*TEMP_W-1:0]  snap_temp_flat,
    output logic [DEG_W-1:0]         snap_deg
);
    localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [IW-1:0] ivl_cnt;

    assign tick = (ivl_cnt == IW'(INTERVAL - 1));

    // Interval timer: wraps at INTERVAL-1.
    always_ff @(posedge clk) begin
        if (!rst_n)    ivl_cnt <= '0;
        else if (tick) ivl_cnt <= '0;
        else           ivl_cnt <= ivl_cnt + 1'b1;
    end

    // Captured temperature and degradation, refreshed on each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_temp_flat <= '0;
            snap_deg       <= '0;
        end else if (tick) begin
            snap_temp_flat <= temp_flat;
            snap_deg       <= perf_deg;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CNT_W-1:0] run_cnt;
        logic [CNT_W-1:0] snap_cnt;

        // Saturating access counter; restarts and captures on the boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_cnt  <= '0;
                snap_cnt <= '0;
            end else if (tick) begin
                snap_cnt <= run_cnt;
                run_cnt  <= CNT_W'(acc_hit[b]);
            end else if (acc_hit[b] && run_cnt != CNT_MAX) begin
                run_cnt  <= run_cnt + 1'b1;
            end
        end

        assign snap_cnt_flat[b*CNT_W +: CNT_W] = snap_cnt;
    end

endmodule

// File: rtl/lgc_remap.sv
// Remap table: one valid bit and one target index per bank.
// Entries are written one at a time and cleared all together. The lookup
// is combinational. Marks every bank that currently serves as a target.
// Assumes: set_en and clr_all are never high together.
module lgc_remap #(
    parameter int NBANK = 16,
    parameter int BW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BW-1:0]    set_idx,
    input  logic [BW-1:0]    set_tgt,
    input  logic             clr_all,
    input  logic [BW-1:0]    lookup_bank,
    output logic [BW-1:0]    lookup_target,
    output logic [NBANK-1:0] tgt_busy
);
    logic [NBANK-1:0] map_vld;
    logic [BW-1:0]    map_tgt [NBANK];

    // Table update: bulk clear on wake, single write after a drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_vld <= '0;
            for (int i = 0; i < NBANK; i++) map_tgt[i] <= '0;
        end else if (clr_all) begin
            map_vld <= '0;
        end else if (set_en) begin
            map_vld[set_idx] <= 1'b1;
            map_tgt[set_idx] <= set_tgt;
        end
    end

    // Redirect lookup: the original index unless the entry is valid.
    always_comb begin
        lookup_target = map_vld[lookup_bank] ? map_tgt[lookup_bank] : lookup_bank;
    end

    // Target occupancy: a bank is busy if any valid entry points at it.
    always_comb begin
        tgt_busy = '0;
        for (int j = 0; j < NBANK; j++) begin
            if (map_vld[j]) tgt_busy[map_tgt[j]] = 1'b1;
        end
    end

endmodule

// File: rtl/lgc_pick.sv
// Victim and target selection from captured statistics (combinational).
// Victim: the hottest powered bank that is not a target; in clustered mode
// group leaders are excluded. Target: in clustered mode the group leader,
// otherwise the least-used powered bank other than the victim.
// Assumes: GROUP is a power of two >= 2 and divides NBANK.
module lgc_pick #(
    parameter int NBANK  = 16,
    parameter int BW     = 4,
    parameter int CNT_W  = 16,
    parameter int TEMP_W = 8,
    parameter int GROUP  = 4
) (
    input  logic [NBANK-1:0]        pg_en,
    input  logic [NBANK-1:0]        tgt_busy,
    input  logic [NBANK*CNT_W-1:0]  snap_cnt_flat,
    input  logic [NBANK*TEMP_W-1:0] snap_temp_flat,
    input  logic                    cluster_mode,
    output logic                    pick_ok,
    output logic [BW-1:0]           vic_idx,
    output logic [BW-1:0]           dst_idx
);
    localparam int GW = $clog2(GROUP);

    logic [CNT_W-1:0]  cnt_a  [NBANK];
    logic [TEMP_W-1:0] temp_a [NBANK];
    logic              vic_found;
    logic              free_found;
    logic [BW-1:0]     free_idx;
    logic [BW-1:0]     lead_idx;
    logic [TEMP_W-1:0] best_t;
    logic [CNT_W-1:0]  best_c;

    for (genvar b = 0; b < NBANK; b++) begin : g_unpack
        assign cnt_a[b]  = snap_cnt_flat[b*CNT_W +: CNT_W];
        assign temp_a[b] = snap_temp_flat[b*TEMP_W +: TEMP_W];
    end

    // Victim search: strict greater-than keeps the lowest index on ties.
    always_comb begin
        vic_found = 1'b0;
        vic_idx   = '0;
        best_t    = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (pg_en[i] && !tgt_busy[i] && !(cluster_mode && (i % GROUP == 0))) begin
                if (!vic_found || temp_a[i] > best_t) begin
                    vic_found = 1'b1;
                    vic_idx   = BW'(i);
                    best_t    = temp_a[i];
                end
            end
        end
    end

    // Free-mode target search: fewest accesses, lowest index on ties.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        best_c     = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (pg_en[i] && BW'(i) != vic_idx) begin
                if (!free_found || cnt_a[i] < best_c) begin
                    free_found = 1'b1;
                    free_idx   = BW'(i);
                    best_c     = cnt_a[i];
                end
            end
        end
    end

    // Group leader of the victim: low index bits forced to zero.
    assign lead_idx = {vic_idx[BW-1:GW], {GW{1'b0}}};

    // Final choice by mode.
    always_comb begin
        dst_idx = cluster_mode ? lead_idx : free_idx;
        pick_ok = vic_found && (cluster_mode || free_found);
    end

endmodule

// File: rtl/llc_gate_ctrl.sv
// Top of the cache bank gating controller.
// Sequences decide -> drain -> gate, or decide -> wake -> clear remap.
// Interval boundaries that arrive while busy are held until idle.
// Assumes: the migration engine answers flush_req with a one-cycle
// flush_done; cluster_mode changes only while every bank is powered.
module llc_gate_ctrl
    import llc_gate_pkg::*;
#(
    parameter int NBANK    = 16,
    parameter int GROUP    = 4,
    parameter int CNT_W    = 16,
    parameter int TEMP_W   = 8,
    parameter int DEG_W    = 8,
    parameter int INTERVAL = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NBANK-1:0]           acc_hit,
    input  logic [NBANK*TEMP_W-1:0]    temp_flat,
    input  logic [DEG_W-1:0]           perf_deg,
    input  logic [DEG_W-1:0]           deg_limit,
    input  logic                       cluster_mode,
    input  logic                       flush_done,
    input  logic [$clog2(NBANK)-1:0]   lookup_bank,
    output logic [NBANK-1:0]           pg_en,
    output logic                       flush_req,
    output logic [$clog2(NBANK)-1:0]   flush_src,
    output logic [$clog2(NBANK)-1:0]   flush_dst,
    output logic [NBANK-1:0]           stall,
    output logic [$clog2(NBANK)-1:0]   lookup_target
);
    localparam int BW      = $clog2(NBANK);
    localparam int OFF_CAP = NBANK / 2;

    gate_state_e               state;
    logic                      pending;
    logic                      tick;
    logic [NBANK*CNT_W-1:0]    snap_cnt_flat;
    logic [NBANK*TEMP_W-1:0]   snap_temp_flat;
    logic [DEG_W-1:0]          snap_deg;
    logic [NBANK-1:0]          tgt_busy;
    logic                      pick_ok;
    logic [BW-1:0]             vic_idx;
    logic [BW-1:0]             dst_idx;
    logic [BW:0]               off_cnt;
    logic                      over_budget;
    logic                      any_off;
    logic                      map_set;
    logic                      map_clr;

    lgc_stats #(
        .NBANK(NBANK), .CNT_W(CNT_W), .TEMP_W(TEMP_W),
        .DEG_W(DEG_W), .INTERVAL(INTERVAL)
    ) u_stats (
        .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit), .temp_flat(temp_flat),
        .perf_deg(perf_deg), .tick(tick), .snap_cnt_flat(snap_cnt_flat),
        .snap_temp_flat(snap_temp_flat), .snap_deg(snap_deg)
    );

    lgc_remap #(.NBANK(NBANK), .BW(BW)) u_remap (
        .clk(clk), .rst_n(rst_n), .set_en(map_set), .set_idx(flush_src),
        .set_tgt(flush_dst), .clr_all(map_clr), .lookup_bank(lookup_bank),
        .lookup_target(lookup_target), .tgt_busy(tgt_busy)
    );

    lgc_pick #(
        .NBANK(NBANK), .BW(BW), .CNT_W(CNT_W), .TEMP_W(TEMP_W), .GROUP(GROUP)
    ) u_pick (
        .pg_en(pg_en), .tgt_busy(tgt_busy), .snap_cnt_flat(snap_cnt_flat),
        .snap_temp_flat(snap_temp_flat), .cluster_mode(cluster_mode),
        .pick_ok(pick_ok), .vic_idx(vic_idx), .dst_idx(dst_idx)
    );

    // Count of gated banks for the cap.
    always_comb begin
        off_cnt = '0;
        for (int i = 0; i < NBANK; i++) off_cnt = off_cnt + (BW+1)'(!pg_en[i]);
    end

    assign any_off     = (off_cnt != '0);
    assign over_budget = (snap_deg > deg_limit);
    assign map_set     = (state == ST_FLUSH) && flush_done;
    assign map_clr     = (state == ST_WAKE);

    // Stall only the receiving bank while a drain is open.
    always_comb begin
        stall = '0;
        if (flush_req) stall[flush_dst] = 1'b1;
    end

    // Deferred-boundary flag: set when a boundary passes while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                                pending <= 1'b0;
        else if (tick && state != ST_IDLE)         pending <= 1'b1;
        else if (state == ST_IDLE)                 pending <= 1'b0;
    end

    // Sequencer: decision, drain handshake, gating and wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pg_en     <= '1;
            flush_req <= 1'b0;
            flush_src <= '0;
            flush_dst <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (tick || pending) state <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (over_budget) begin
                        if (any_off) begin
                            pg_en <= '1;
                            state <= ST_WAKE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (pick_ok && off_cnt < (BW+1)'(OFF_CAP)) begin
                        flush_req <= 1'b1;
                        flush_src <= vic_idx;
                        flush_dst <= dst_idx;
                        state     <= ST_FLUSH;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    if (flush_done) begin
                        flush_req        <= 1'b0;
                        pg_en[flush_src] <= 1'b0;
                        state            <= ST_IDLE;
                    end
                end
                ST_WAKE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lgc_checker.sv
// Temporal checks for llc_gate_ctrl, attached with the bind below.
// Assumes: the bound instance uses the top's own NBANK and BW.
module lgc_checker #(
    parameter int NBANK = 16,
    parameter int BW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] pg_en,
    input logic             flush_req,
    input logic             flush_done,
    input logic [BW-1:0]    flush_src,
    input logic [BW-1:0]    flush_dst,
    input logic [NBANK-1:0] stall,
    input logic [BW-1:0]    lookup_target
);
    AST_OFF_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pg_en) <= NBANK/2); // R1

    AST_GATE_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pg_en) & ~pg_en)) |-> $past(flush_req && flush_done)); // R4

    AST_DRAIN_BANKS_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (pg_en[flush_src] && pg_en[flush_dst])); // R4

    AST_STALL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stall)); // R5

    AST_SRC_NOT_DST: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (flush_src != flush_dst)); // R6

    AST_DRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> (flush_req && $stable(flush_src) && $stable(flush_dst))); // R7

    AST_LOOKUP_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        pg_en[lookup_target]); // R9

endmodule

bind llc_gate_ctrl lgc_checker #(.NBANK(NBANK), .BW(BW)) u_lgc_chk (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .flush_req(flush_req),
    .flush_done(flush_done), .flush_src(flush_src), .flush_dst(flush_dst),
    .stall(stall), .lookup_target(lookup_target)
);

// File: tb/test_llc_gate_ctrl.sv
// Bench for llc_gate_ctrl: behavioural per-cycle reference model compared
// every clock, plus directed phases for the narrow corner cases.
module test_llc_gate_ctrl;
    localparam int NB   = 16;
    localparam int INTV = 32;
    localparam int CW   = 8;
    localparam int TW   = 8;
    localparam int DW   = 8;
    localparam int BW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB-1:0]     acc_hit = '0;
    logic [NB*TW-1:0]  temp_flat;
    logic [DW-1:0]     perf_deg = '0;
    logic [DW-1:0]     deg_limit = 8'd3;
    logic              cluster_mode = 1'b0;
    logic              flush_done = 1'b0;
    logic [BW-1:0]     lookup_bank = '0;
    logic [NB-1:0]     pg_en;
    logic              flush_req;
    logic [BW-1:0]     flush_src;
    logic [BW-1:0]     flush_dst;
    logic [NB-1:0]     stall;
    logic [BW-1:0]     lookup_target;

    logic [TW-1:0]     temps [NB];
    int                w [NB];
    int                fl_delay = 2;
    int                fl_wait = 0;
    int                lb_force = -1;
    int                cyc = 0;
    int                n_tests = 0;
    int                n_fail = 0;
    int                wd = 0;

    // Reference model state.
    int  m_cnt [NB];
    int  m_snc [NB];
    int  m_snt [NB];
    int  m_tgt [NB];
    bit  m_pg  [NB];
    bit  m_val [NB];
    int  m_sdeg, m_ivl, m_st, m_pend, m_src, m_dst;
    bit  m_freq;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) temp_flat[i*TW +: TW] = temps[i];
    end

    llc_gate_ctrl #(
        .NBANK(NB), .GROUP(4), .CNT_W(CW), .TEMP_W(TW), .DEG_W(DW), .INTERVAL(INTV)
    ) i_llc_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit), .temp_flat(temp_flat),
        .perf_deg(perf_deg), .deg_limit(deg_limit), .cluster_mode(cluster_mode),
        .flush_done(flush_done), .lookup_bank(lookup_bank), .pg_en(pg_en),
        .flush_req(flush_req), .flush_src(flush_src), .flush_dst(flush_dst),
        .stall(stall), .lookup_target(lookup_target)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference model: advances one step per rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                m_cnt[i] = 0; m_snc[i] = 0; m_snt[i] = 0; m_tgt[i] = 0;
                m_pg[i] = 1; m_val[i] = 0;
            end
            m_sdeg = 0; m_ivl = 0; m_st = 0; m_pend = 0; m_src = 0; m_dst = 0; m_freq = 0;
        end else begin
            int  st0;
            bit  tk;
            int  offc;
            int  vi, bt, di, bc;
            bit  vf, df, busy;
            st0 = m_st;
            tk  = (m_ivl == INTV - 1);
            offc = 0;
            for (int i = 0; i < NB; i++) if (!m_pg[i]) offc++;
            case (st0)
                0: if (tk || m_pend != 0) begin m_st = 1; m_pend = 0; end
                1: begin
                    if (m_sdeg > int'(deg_limit)) begin
                        if (offc > 0) begin
                            for (int i = 0; i < NB; i++) m_pg[i] = 1;
                            m_st = 3;
                        end else m_st = 0;
                    end else begin
                        vf = 0; vi = 0; bt = -1;
                        for (int i = 0; i < NB; i++) begin
                            busy = 0;
                            for (int j = 0; j < NB; j++) if (m_val[j] && m_tgt[j] == i) busy = 1;
                            if (m_pg[i] && !busy && !(cluster_mode && (i % 4 == 0)) && m_snt[i] > bt) begin
                                vf = 1; vi = i; bt = m_snt[i];
                            end
                        end
                        df = 0; di = 0; bc = 1 << 30;
                        if (cluster_mode) begin
                            di = vi - (vi % 4); df = 1;
                        end else begin
                            for (int i = 0; i < NB; i++)
                                if (m_pg[i] && i != vi && m_snc[i] < bc) begin df = 1; di = i; bc = m_snc[i]; end
                        end
                        if (vf && df && offc < NB/2) begin
                            m_freq = 1; m_src = vi; m_dst = di; m_st = 2;
                        end else m_st = 0;
                    end
                end
                2: if (flush_done) begin
                    m_freq = 0; m_pg[m_src] = 0; m_val[m_src] = 1; m_tgt[m_src] = m_dst; m_st = 0;
                end
                default: begin
                    for (int i = 0; i < NB; i++) m_val[i] = 0;
                    m_st = 0;
                end
            endcase
            if (tk && st0 != 0) m_pend = 1;
            if (tk) begin
                for (int i = 0; i < NB; i++) begin
                    m_snc[i] = m_cnt[i];
                    m_cnt[i] = acc_hit[i] ? 1 : 0;
                    m_snt[i] = temps[i];
                end
                m_sdeg = perf_deg;
                m_ivl = 0;
            end else begin
                for (int i = 0; i < NB; i++) if (acc_hit[i] && m_cnt[i] < 255) m_cnt[i]++;
                m_ivl++;
            end
        end
    end

    // Mid-cycle: compare against the model, then drive the next inputs.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NB-1:0] epg;
            logic [NB-1:0] est;
            int lb;
            for (int i = 0; i < NB; i++) epg[i] = m_pg[i];
            est = '0;
            if (m_freq) est[m_dst] = 1'b1;
            lb = int'(lookup_bank);
            check("R1/R2/R8", "pg_en", pg_en, epg);
            check("R4/R7", "flush_req", flush_req, m_freq);
            if (m_freq) begin
                check("R3/R10", "flush_src", flush_src, m_src);
                check("R6/R8", "flush_dst", flush_dst, m_dst);
            end
            check("R5", "stall", stall, est);
            check("R9", "lookup_target", lookup_target, m_val[lb] ? m_tgt[lb] : lb);
        end
        for (int i = 0; i < NB; i++) acc_hit[i] = rst_n && (($urandom % 100) < w[i]);
        if (flush_done) flush_done = 1'b0;
        else if (flush_req) begin
            if (fl_wait >= fl_delay) begin flush_done = 1'b1; fl_wait = 0; end
            else fl_wait++;
        end
        lookup_bank = (lb_force >= 0) ? BW'(lb_force) : BW'(cyc % NB);
        cyc++;
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL watchdog R7: cycles %0d expected <= %0d", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic wait_pg(input logic [NB-1:0] v, input int lim);
        for (int k = 0; k < lim && pg_en != v; k++) begin @(posedge clk); #1; end
    endtask

    task automatic wait_req(input logic v, input int lim);
        for (int k = 0; k < lim && flush_req != v; k++) begin @(posedge clk); #1; end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            temps[i] = TW'(50 + 5*i);
            w[i] = (i == 0) ? 0 : 30 + i;
        end
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state.
        check("R1", "reset pg_en", pg_en, 16'hFFFF);
        check("R4", "reset flush_req", flush_req, 0);
        check("R5", "reset stall", stall, 0);

        // Phase A: free mode, budget met; hottest banks drain into bank 0.
        fl_delay = 3;
        wait_req(1'b1, 200);
        check("R3", "first victim", flush_src, 15);
        check("R6", "first target", flush_dst, 0);
        check("R5", "stall during drain", stall, 16'h0001);
        wait_pg(16'h00FF, 2000);
        check("R1", "eight banks off", pg_en, 16'h00FF);
        step(4*INTV);
        check("R1", "cap holds", pg_en, 16'h00FF);
        check("R1", "no drain at cap", flush_req, 0);

        // Phase B: over budget wakes everything; redirect lasts one cycle.
        lb_force = 15;
        perf_deg = 8'd5;
        step(2);
        wait_pg(16'hFFFF, 200);
        check("R2", "woken pg_en", pg_en, 16'hFFFF);
        check("R2", "redirect kept one cycle", lookup_target, 0);
        step(1);
        check("R2", "redirect cleared", lookup_target, 15);
        step(3*INTV);
        check("R2", "no drain over budget", pg_en, 16'hFFFF);

        // Phase C: degradation equal to limit; long drain defers a boundary.
        lb_force = -1;
        perf_deg = 8'd3;
        fl_delay = 45;
        wait_req(1'b1, 200);
        check("R3", "victim at equal budget", flush_src, 15);
        wait_req(1'b0, 200);
        check("R4", "gated after ack", pg_en[15], 0);
        step(1);
        check("R7", "gap cycle", flush_req, 0);
        step(1);
        check("R7", "deferred decision", flush_req, 1);
        check("R3", "second victim", flush_src, 14);

        // Phase D: mixed traffic, temperatures and budget.
        for (int k = 0; k < 60; k++) begin
            for (int i = 0; i < NB; i++) begin
                temps[i] = TW'($urandom % 200);
                w[i] = int'($urandom % 90);
            end
            perf_deg = DW'($urandom % 7);
            fl_delay = int'($urandom % 40);
            step(40);
        end

        // Phase E: clustered mode with leaders hottest.
        perf_deg = 8'd9;
        fl_delay = 2;
        for (int k = 0; k < 400 && (pg_en != 16'hFFFF || flush_req); k++) step(1);
        step(4);
        check("R2", "all on before mode change", pg_en, 16'hFFFF);
        cluster_mode = 1'b1;
        for (int i = 0; i < NB; i++) temps[i] = (i % 4 == 0) ? 8'd220 : TW'(50 + 5*i);
        perf_deg = 8'd0;
        wait_pg(16'h113F, 3000);
        check("R8", "leaders stay on", pg_en, 16'h113F);
        lb_force = 15;
        step(2);
        check("R8", "redirect to leader", lookup_target, 12);
        step(3*INTV);
        check("R1", "cap in clustered mode", pg_en, 16'h113F);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule